// File: doc/BRIEF.md
# Rule-60 Cellular Automaton Test Pattern Source

This block produces one test pattern per clock for built-in self-test of combinational logic. Its state is a row of cells, and every cell is one flip-flop. On each advancing clock, each cell takes the XOR of its own value and the value of its lower-index neighbour. The lowest cell has a constant 0 as its neighbour. Read as a polynomial over GF(2), with bit i as the coefficient of x^i, one step multiplies the state by (x+1) and drops the terms of degree N and above. All cells drive the parallel pattern output.

A synchronous seed load sets the starting state, and an enable input advances the automaton. The sequence period depends on the seed and can be far shorter than 2^N-1, so the block never relies on a maximal-length sequence. The all-zero state is a fixed point. A status output flags it, and the state stays zero until a new seed is loaded.

The weight a seed gives to each output differs widely. A balanced seed gives outputs that are 1 about half the time. A seed holding a single 1 makes some outputs almost always 0 and lets others exceed 0.7. An output-weight monitor measures this on chip: it counts the ones on one chosen output over a programmable number of advancing cycles.

Top module: `ca_pattern_gen`

## Requirements
- R1: While rst_ni is low and after its release, before any other stimulus, pattern_o equals parameter RST_SEED (default 1), zero_state_o is 0, mon_done_o is 0 and mon_count_o is 0.
- R2: On a clock edge with enable_i=1 and seed_load_i=0, each bit i>=1 of pattern_o becomes old bit i XOR old bit i-1. Equivalently, the new pattern is (p ^ (p<<1)) truncated to N_CELLS bits.
- R3: Bit 0 has a null boundary, so no step changes its value.
- R4: On a clock edge with seed_load_i=1, pattern_o becomes seed_i, whatever the value of enable_i.
- R5: On a clock edge with enable_i=0 and seed_load_i=0, pattern_o keeps its value.
- R6: zero_state_o is 1 exactly when pattern_o is all zero. An all-zero pattern stays zero through any number of steps until a seed is loaded.
- R7: No maximal period is assumed. With N_CELLS a power of two, every seed returns after exactly N_CELLS steps, because (x+1)^N = x^N + 1.
- R8: A clock edge with mon_start_i=1 latches mon_sel_i and mon_window_i and clears the tally. The tally then adds pattern_o[sel] as it stands before each advancing edge, over the next W advancing edges (an advancing edge has enable_i=1 and seed_load_i=0).
- R9: After the W-th advancing edge, mon_done_o is 1 for exactly one cycle and mon_count_o shows the tally. mon_count_o then holds that value until the next result.
- R10: Edges that do not advance the automaton neither add to the tally nor use up the window.
- R11: A start with mon_window_i=0 gives mon_done_o=1 and mon_count_o=0 after the next edge.
- R12: A start while a measurement is running drops that measurement and begins a new one with the new select and window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load seed_i at the next edge |
| seed_i | input | N_CELLS | Seed value |
| enable_i | input | 1 | Advance the automaton one step |
| pattern_o | output | N_CELLS | Parallel test pattern (cell states) |
| zero_state_o | output | 1 | State is the all-zero fixed point |
| mon_start_i | input | 1 | Start a weight measurement |
| mon_sel_i | input | SEL_W | Output bit to measure |
| mon_window_i | input | WIN_W | Number of advancing cycles in the window |
| mon_count_o | output | WIN_W | Ones counted in the last finished window |
| mon_done_o | output | 1 | One-cycle pulse when a result is ready |

## Verification
The bench changes inputs on falling edges and samples one falling edge later. A load or a step therefore shows on pattern_o, and on zero_state_o, half a cycle after the rising edge that took it. A measurement's start edge does not count. The result and the done pulse appear half a cycle after the W-th advancing edge, and the bench also checks that the pulse has dropped one cycle later. The bench tracks expected patterns and tallies with the shift-and-XOR product in the same cycle order, across a full sweep of every 8-bit seed, windows with gaps in the enable, a zero-length window and a restart.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic {MON_IDLE = 1'b0, MON_RUN = 1'b1} mon_state_e;
endpackage

// File: rtl/ca_cell.sv
module ca_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic seed_bit_i,
  input  logic adv_i,
  input  logic left_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (load_i) q_o <= seed_bit_i;
    else if (adv_i)  q_o <= q_o ^ left_i;
  end
endmodule

// File: rtl/ca_zero_detect.sv
module ca_zero_detect #(
  parameter int N_CELLS = 16
) (
  input  logic [N_CELLS-1:0] state_i,
  output logic               zero_o
);
  assign zero_o = ~|state_i;
endmodule

// File: rtl/ca_weight_mon.sv
module ca_weight_mon #(
  parameter int N_CELLS = 16,
  parameter int WIN_W   = 10,
  localparam int SEL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [WIN_W-1:0]   window_i,
  input  logic               adv_i,
  input  logic [N_CELLS-1:0] pattern_i,
  output logic [WIN_W-1:0]   count_o,
  output logic               done_o
);
  import ca_pkg::*;

  mon_state_e       state_q;
  logic [SEL_W-1:0] sel_q;
  logic [WIN_W-1:0] rem_q;
  logic [WIN_W-1:0] acc_q;
  logic [WIN_W-1:0] bit_ext;

  assign bit_ext = {{(WIN_W-1){1'b0}}, pattern_i[sel_q]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_IDLE;
      sel_q   <= '0;
      rem_q   <= '0;
      acc_q   <= '0;
      count_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sel_q <= sel_i;
        rem_q <= window_i;
        acc_q <= '0;
        if (window_i == '0) begin
          state_q <= MON_IDLE;
          count_o <= '0;
          done_o  <= 1'b1;
        end else begin
          state_q <= MON_RUN;
        end
      end else if (state_q == MON_RUN && adv_i) begin
        if (rem_q == WIN_W'(1)) begin
          count_o <= acc_q + bit_ext;
          done_o  <= 1'b1;
          state_q <= MON_IDLE;
        end else begin
          acc_q <= acc_q + bit_ext;
          rem_q <= rem_q - WIN_W'(1);
        end
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  assert_idle_cycle_no_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == MON_RUN && !adv_i && !start_i |=> $stable(acc_q) && $stable(rem_q));

  assert_zero_window_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && window_i == '0 |=> done_o && count_o == '0);
endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
  parameter int N_CELLS = 16,
  parameter int WIN_W   = 10,
  parameter logic [N_CELLS-1:0] RST_SEED = N_CELLS'(1),
  localparam int SEL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seed_load_i,
  input  logic [N_CELLS-1:0] seed_i,
  input  logic               enable_i,
  output logic [N_CELLS-1:0] pattern_o,
  output logic               zero_state_o,
  input  logic               mon_start_i,
  input  logic [SEL_W-1:0]   mon_sel_i,
  input  logic [WIN_W-1:0]   mon_window_i,
  output logic [WIN_W-1:0]   mon_count_o,
  output logic               mon_done_o
);
  logic adv;
  logic [N_CELLS-1:0] left;

  // load wins over enable
  assign adv = enable_i & ~seed_load_i;

  // null boundary on cell 0
  assign left = {pattern_o[N_CELLS-2:0], 1'b0};

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    ca_cell #(.RST_VAL(RST_SEED[i])) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (seed_load_i),
      .seed_bit_i (seed_i[i]),
      .adv_i      (adv),
      .left_i     (left[i]),
      .q_o        (pattern_o[i])
    );
  end

  ca_zero_detect #(.N_CELLS(N_CELLS)) u_zero (
    .state_i (pattern_o),
    .zero_o  (zero_state_o)
  );

  ca_weight_mon #(.N_CELLS(N_CELLS), .WIN_W(WIN_W)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (mon_start_i),
    .sel_i     (mon_sel_i),
    .window_i  (mon_window_i),
    .adv_i     (adv),
    .pattern_i (pattern_o),
    .count_o   (mon_count_o),
    .done_o    (mon_done_o)
  );

  assert_cell0_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_load_i |=> pattern_o[0] == $past(pattern_o[0]));

  assert_seed_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> pattern_o == $past(seed_i));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_load_i && !enable_i |=> $stable(pattern_o));

  assert_zero_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_state_o && !seed_load_i |=> zero_state_o);
endmodule

// File: tb/ca_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module ca_pattern_gen_tb_top;
  localparam int N = 8;
  localparam int WW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic [N-1:0] seed = '0;
  logic enable = 1'b0;
  logic [N-1:0] pattern;
  logic zero_state;
  logic mon_start = 1'b0;
  logic [2:0] mon_sel = '0;
  logic [WW-1:0] mon_win = '0;
  logic [WW-1:0] mon_count;
  logic mon_done;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ca_pattern_gen #(.N_CELLS(N), .WIN_W(WW), .RST_SEED(8'h01)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .seed_load_i(seed_load), .seed_i(seed),
    .enable_i(enable), .pattern_o(pattern), .zero_state_o(zero_state),
    .mon_start_i(mon_start), .mon_sel_i(mon_sel), .mon_window_i(mon_win),
    .mon_count_o(mon_count), .mon_done_o(mon_done)
  );

  function automatic logic [N-1:0] step(input logic [N-1:0] v);
    return v ^ (v << 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // seed, select, window; gaps drops enable on every third cycle
  task automatic mon_run(input logic [N-1:0] s, input int sel, input int win, input bit gaps);
    logic [N-1:0] cur;
    int exp_cnt;
    int got;
    int i;
    cur = s; exp_cnt = 0; got = 0; i = 0;
    @(negedge clk);
    seed_load = 1; seed = s; mon_start = 1; mon_sel = 3'(sel); mon_win = WW'(win); enable = 1;
    @(negedge clk);
    seed_load = 0; mon_start = 0;
    while (got < win) begin
      enable = !(gaps && (i % 3 == 2));
      if (enable) begin
        if (cur[sel]) exp_cnt++;
        cur = step(cur);
        got++;
      end
      @(negedge clk);
      i++;
      if (got < win) check(mon_done == 1'b0, "R10 early done", int'(mon_done), 0);
    end
    check(mon_done == 1'b1, "R9 done pulse", int'(mon_done), 1);
    check(int'(mon_count) == exp_cnt, "R8 window count", int'(mon_count), exp_cnt);
    check(pattern == cur, "R2 pattern after window", int'(pattern), int'(cur));
    enable = 0;
    @(negedge clk);
    check(mon_done == 1'b0, "R9 pulse width", int'(mon_done), 0);
    check(int'(mon_count) == exp_cnt, "R9 count held", int'(mon_count), exp_cnt);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] cur;
    int exp_cnt;
    repeat (3) @(negedge clk);
    check(pattern == 8'h01, "R1 reset pattern", int'(pattern), 1);
    check(zero_state == 1'b0, "R1 reset zero flag", int'(zero_state), 0);
    rst_n = 1;
    @(negedge clk);
    check(pattern == 8'h01, "R1 pattern after release", int'(pattern), 1);
    check(mon_done == 1'b0 && mon_count == '0, "R1 monitor idle", int'(mon_count), 0);

    // R5: hold with enable low
    repeat (3) @(negedge clk);
    check(pattern == 8'h01, "R5 hold", int'(pattern), 1);

    // exhaustive sweep: load (enable high too), N steps, recurrence
    for (int s = 0; s < 256; s++) begin
      @(negedge clk);
      seed_load = 1; seed = 8'(s); enable = 1;
      @(negedge clk);
      seed_load = 0;
      check(pattern == 8'(s), "R4 load overrides enable", int'(pattern), s);
      cur = 8'(s);
      for (int k = 0; k < N; k++) begin
        @(negedge clk);
        cur = step(cur);
        if (pattern != cur) check(0, "R2 step", int'(pattern), int'(cur));
        else check(1, "R2 step", 0, 0);
        check(pattern[0] == s[0], "R3 cell 0 fixed", int'(pattern[0]), int'(s[0]));
        check(zero_state == (cur == '0), "R6 zero flag", int'(zero_state), int'(cur == '0));
      end
      check(pattern == 8'(s), "R7 period N", int'(pattern), s);
      enable = 0;
    end

    // R6: zero state sticks until a seed arrives
    @(negedge clk); seed_load = 1; seed = '0;
    @(negedge clk); seed_load = 0; enable = 1;
    repeat (5) @(negedge clk);
    check(pattern == '0 && zero_state, "R6 zero fixed point", int'(pattern), 0);
    seed_load = 1; seed = 8'h80;
    @(negedge clk); seed_load = 0; enable = 0;
    check(pattern == 8'h80 && !zero_state, "R6 leave zero by load", int'(pattern), 128);

    // monitor windows
    mon_run(8'h01, 7, 8, 1'b0);
    mon_run(8'h01, 0, 8, 1'b0);
    mon_run(8'h01, 2, 16, 1'b1);
    mon_run(8'hA5, 3, 13, 1'b1);
    mon_run(8'h3C, 5, 63, 1'b0);
    mon_run(8'h01, 1, 1, 1'b0);

    // R11: zero window
    @(negedge clk); mon_start = 1; mon_win = '0; mon_sel = 3'd4; enable = 0;
    @(negedge clk); mon_start = 0;
    check(mon_done == 1'b1 && mon_count == '0, "R11 zero window", int'(mon_count), 0);
    @(negedge clk);
    check(mon_done == 1'b0, "R11 single pulse", int'(mon_done), 0);

    // R12: restart mid-window
    @(negedge clk); seed_load = 1; seed = 8'h0F; mon_start = 1; mon_sel = 3'd1; mon_win = 6'd5; enable = 0;
    @(negedge clk); seed_load = 0; mon_start = 0; enable = 1;
    cur = 8'h0F;
    repeat (2) begin @(negedge clk); cur = step(cur); end
    enable = 0; mon_start = 1; mon_sel = 3'd6; mon_win = 6'd3;
    @(negedge clk); mon_start = 0; enable = 1;
    exp_cnt = 0;
    for (int k = 0; k < 3; k++) begin
      if (cur[6]) exp_cnt++;
      cur = step(cur);
      @(negedge clk);
      if (k < 2) check(mon_done == 1'b0, "R12 no stale result", int'(mon_done), 0);
    end
    check(mon_done == 1'b1 && int'(mon_count) == exp_cnt, "R12 restart count",
          int'(mon_count), exp_cnt);
    enable = 0;
    @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule